// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the decode stage of a hart that supports supervisor and hypervisor privilege. For a small set of system instructions it decides, from the current privilege level, the virtualization state, the trap-control bits and whether supervisor mode is implemented, what should happen. There are three possible outcomes: the instruction proceeds, it raises an illegal-instruction exception, or it raises a virtual-instruction fault.

The covered instructions are:
- the wait-for-interrupt instruction;
- the non-timeout wait-on-reservation hint;
- the supervisor translation fence;
- the two hypervisor fences, one for guest-virtual and one for guest-physical addresses;
- hypervisor virtual-machine loads and stores, in both data and execute-permission flavours;
- accesses to the entropy-seed CSR.

When an instruction proceeds, the block also raises one side-effect strobe. This is a halt request, a translation-flush request, or the effective two-stage access mode for a hypervisor load/store. The caller presents the instruction with a one-cycle valid strobe. The block registers that strobe together with its context, and the verdict appears combinationally from the registered copy one cycle later.

Top module: `plc_top`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `op_valid` high. While `res_valid` is low, `verdict`, `cause`, `halt_req`, `flush_req`, `hls_valid` and `hls_mode` are all zero.
- R2: `verdict` is encoded 0 = proceed, 1 = illegal instruction, 2 = virtual-instruction fault. `cause` is 2 for illegal, 22 for virtual-instruction fault and 0 for proceed. Privilege is encoded 0 = user, 1 = supervisor, 3 = machine.
- R3: For `op_kind` 0 (wait-for-interrupt), the result is illegal when either of two conditions holds. The first is `trap_wait` set while privilege is supervisor, or while privilege is user with `has_smode` clear. The second is privilege user with `has_smode` set and `virt_on` clear.
- R4: For `op_kind` 0, when not illegal, the result is a virtual-instruction fault if `virt_on` is set and either privilege is user, or privilege is supervisor with `vtrap_wait` set. Otherwise it proceeds with `halt_req` high.
- R5: For `op_kind` 1 (wait-on-reservation hint), the result is a virtual-instruction fault when `virt_on` is set, privilege is user or supervisor, `vtrap_wait` is set and `trap_wait` is clear. Otherwise it is illegal when privilege is below machine and `trap_wait` is set. Otherwise it proceeds, with no strobe.
- R6: For `op_kind` 2 (supervisor fence), the result is illegal when `virt_on` is clear and either privilege is user or privilege is supervisor with `trap_vm` set. It is a virtual-instruction fault when `virt_on` is set and either privilege is user or `vtrap_vm` is set. Otherwise it proceeds with `flush_req` high.
- R7: For `op_kind` 3 (guest-virtual hypervisor fence), the result is a virtual-instruction fault whenever `virt_on` is set. Otherwise it proceeds with `flush_req` high at machine or supervisor privilege, and is illegal at user privilege.
- R8: For `op_kind` 4 (guest-physical hypervisor fence), the result is illegal at non-virtualized supervisor privilege with `trap_vm` set. In every other case the R7 rules apply.
- R9: For `op_kind` 5 (data) and 6 (execute) hypervisor load/store, the result always proceeds at machine privilege. Below machine, it is a virtual-instruction fault when `virt_on` is set, and illegal at user privilege with `hyp_user` clear. Otherwise it proceeds.
- R10: When a hypervisor load/store proceeds, `hls_valid` is high and `hls_mode` has the following fields. Bit 2 is the two-stage flag and is always 1. Bit 1 is the guest-SUM variant, set only for `op_kind` 5 with `spvp` set and `guest_sum` set. Bit 0 equals `spvp`.
- R11: For `op_kind` 7 (entropy-seed CSR access), the result is illegal when `seed_ro` is set, and proceeds with no strobe when it is clear.
- R12: While `rst` is high, and in the cycle after it is released with no request, `res_valid` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe for one instruction |
| op_kind | input | 3 | Instruction selector (see R3 to R11) |
| priv | input | 2 | Current privilege level |
| virt_on | input | 1 | Hart is running virtualized |
| has_smode | input | 1 | Supervisor mode is implemented |
| trap_wait | input | 1 | Timeout-wait trap bit (machine status) |
| vtrap_wait | input | 1 | Virtual timeout-wait trap bit (hypervisor status) |
| trap_vm | input | 1 | Trap-virtual-memory bit (machine status) |
| vtrap_vm | input | 1 | Virtual trap-virtual-memory bit (hypervisor status) |
| hyp_user | input | 1 | Hypervisor load/store allowed from user mode |
| spvp | input | 1 | Supervisor-previous-virtual-privilege field |
| guest_sum | input | 1 | Guest supervisor-user-memory-access bit |
| seed_ro | input | 1 | Seed CSR access uses a read-only form |
| res_valid | output | 1 | Result is valid this cycle |
| verdict | output | 2 | 0 proceed, 1 illegal, 2 virtual-instruction fault |
| cause | output | 5 | Exception code for the verdict |
| halt_req | output | 1 | Request to halt until interrupt |
| flush_req | output | 1 | Request to flush address translations |
| hls_valid | output | 1 | Hypervisor load/store may proceed |
| hls_mode | output | 3 | Effective two-stage access mode |

## Verification
The bench builds the block with its default parameters: a 5-bit cause field and exception codes 2 and 22. With eight instruction kinds, three privilege levels and ten single-bit context inputs, the complete input space is about 24,000 combinations. The bench therefore sweeps every one of them and compares verdict, cause and all strobes against values it derives itself. This sweep puts every rule-ordering corner within reach, such as a wait hint with both trap bits set, or a guest-physical fence that is virtualized and has `trap_vm` set.

// File: rtl/plc_pkg.sv
package plc_pkg;

    typedef enum logic [2:0] {
        OP_WFI      = 3'd0,
        OP_WRS      = 3'd1,
        OP_SFENCE   = 3'd2,
        OP_HF_GVIRT = 3'd3,
        OP_HF_GPHYS = 3'd4,
        OP_HLS_DATA = 3'd5,
        OP_HLS_EXEC = 3'd6,
        OP_SEED     = 3'd7
    } op_kind_e;

    typedef enum logic [1:0] {
        VD_PROCEED = 2'd0,
        VD_ILLEGAL = 2'd1,
        VD_VIRT    = 2'd2
    } verdict_e;

    localparam logic [1:0] LVL_U = 2'd0;
    localparam logic [1:0] LVL_S = 2'd1;
    localparam logic [1:0] LVL_M = 2'd3;

    typedef struct packed {
        op_kind_e   kind;
        logic [1:0] lvl;
        logic       virt;
        logic       has_s;
        logic       tw;
        logic       vtw;
        logic       tvm;
        logic       vtvm;
        logic       hu;
        logic       spvp;
        logic       gsum;
        logic       ro;
    } req_ctx_t;

    typedef struct packed {
        verdict_e   vd;
        logic       halt;
        logic       flush;
        logic       hls;
        logic [2:0] mode;
    } decision_t;

    function automatic decision_t proceed_only();
        decision_t d;
        d = '0;
        d.vd = VD_PROCEED;
        return d;
    endfunction

    function automatic decision_t fault(input verdict_e v);
        decision_t d;
        d = '0;
        d.vd = v;
        return d;
    endfunction

endpackage

// File: rtl/plc_capture.sv
module plc_capture
    import plc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  req_ctx_t in_ctx,
    output logic     held_valid,
    output req_ctx_t held_ctx
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_valid <= 1'b0;
            held_ctx   <= '0;
        end else begin
            held_valid <= in_valid;
            if (in_valid) held_ctx <= in_ctx;
        end
    end
endmodule

// File: rtl/plc_rules.sv
module plc_rules
    import plc_pkg::*;
(
    input  req_ctx_t  ctx,
    output decision_t dec
);
    logic is_u, is_s, is_m;

    always_comb begin
        is_u = (ctx.lvl == LVL_U);
        is_s = (ctx.lvl == LVL_S);
        is_m = (ctx.lvl == LVL_M);
    end

    // Guest-virtual fence rules, reused by the guest-physical fence.
    function automatic decision_t gvirt_fence(input req_ctx_t c, input logic m, input logic s);
        decision_t d;
        if (c.virt)                 d = fault(VD_VIRT);
        else if (m || s) begin
            d = proceed_only();
            d.flush = 1'b1;
        end else                    d = fault(VD_ILLEGAL);
        return d;
    endfunction

    always_comb begin
        dec = proceed_only();
        unique case (ctx.kind)
            OP_WFI: begin
                if (((is_s || (!ctx.has_s && is_u)) && ctx.tw) ||
                    (ctx.has_s && is_u && !ctx.virt))
                    dec = fault(VD_ILLEGAL);
                else if (ctx.virt && (is_u || (is_s && ctx.vtw)))
                    dec = fault(VD_VIRT);
                else
                    dec.halt = 1'b1;
            end
            OP_WRS: begin
                if (ctx.virt && (is_s || is_u) && ctx.vtw && !ctx.tw)
                    dec = fault(VD_VIRT);
                else if (!is_m && ctx.tw)
                    dec = fault(VD_ILLEGAL);
            end
            OP_SFENCE: begin
                if (!ctx.virt && (is_u || (is_s && ctx.tvm)))
                    dec = fault(VD_ILLEGAL);
                else if (ctx.virt && (is_u || ctx.vtvm))
                    dec = fault(VD_VIRT);
                else
                    dec.flush = 1'b1;
            end
            OP_HF_GVIRT: dec = gvirt_fence(ctx, is_m, is_s);
            OP_HF_GPHYS: begin
                if (is_s && !ctx.virt && ctx.tvm) dec = fault(VD_ILLEGAL);
                else                              dec = gvirt_fence(ctx, is_m, is_s);
            end
            OP_HLS_DATA, OP_HLS_EXEC: begin
                if (!is_m && ctx.virt)
                    dec = fault(VD_VIRT);
                else if (!is_m && is_u && !ctx.hu)
                    dec = fault(VD_ILLEGAL);
                else begin
                    dec.hls  = 1'b1;
                    dec.mode = {1'b1,
                                (ctx.kind == OP_HLS_DATA) && ctx.spvp && ctx.gsum,
                                ctx.spvp};
                end
            end
            OP_SEED: begin
                if (ctx.ro) dec = fault(VD_ILLEGAL);
            end
            default: dec = proceed_only();
        endcase
    end
endmodule

// File: rtl/plc_emit.sv
module plc_emit
    import plc_pkg::*;
#(
    parameter int CAUSE_W   = 5,
    parameter int ILL_CODE  = 2,
    parameter int VIRT_CODE = 22
) (
    input  logic               valid,
    input  decision_t          dec,
    output logic               out_valid,
    output logic [1:0]         out_verdict,
    output logic [CAUSE_W-1:0] out_cause,
    output logic               out_halt,
    output logic               out_flush,
    output logic               out_hls,
    output logic [2:0]         out_mode
);
    localparam logic [CAUSE_W-1:0] ILL_C  = CAUSE_W'(ILL_CODE);
    localparam logic [CAUSE_W-1:0] VIRT_C = CAUSE_W'(VIRT_CODE);

    always_comb begin
        out_valid   = valid;
        out_verdict = valid ? dec.vd : VD_PROCEED;
        out_halt    = valid && dec.halt;
        out_flush   = valid && dec.flush;
        out_hls     = valid && dec.hls;
        out_mode    = (valid && dec.hls) ? dec.mode : 3'd0;
        out_cause   = '0;
        if (valid) begin
            case (dec.vd)
                VD_ILLEGAL: out_cause = ILL_C;
                VD_VIRT:    out_cause = VIRT_C;
                default:    out_cause = '0;
            endcase
        end
    end
endmodule

// File: rtl/plc_top.sv
module plc_top
    import plc_pkg::*;
#(
    parameter int CAUSE_W   = 5,
    parameter int ILL_CODE  = 2,
    parameter int VIRT_CODE = 22
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_valid,
    input  logic [2:0]         op_kind,
    input  logic [1:0]         priv,
    input  logic               virt_on,
    input  logic               has_smode,
    input  logic               trap_wait,
    input  logic               vtrap_wait,
    input  logic               trap_vm,
    input  logic               vtrap_vm,
    input  logic               hyp_user,
    input  logic               spvp,
    input  logic               guest_sum,
    input  logic               seed_ro,
    output logic               res_valid,
    output logic [1:0]         verdict,
    output logic [CAUSE_W-1:0] cause,
    output logic               halt_req,
    output logic               flush_req,
    output logic               hls_valid,
    output logic [2:0]         hls_mode
);
    req_ctx_t  in_ctx, held_ctx;
    logic      held_valid;
    decision_t dec;

    always_comb begin
        in_ctx.kind  = op_kind_e'(op_kind);
        in_ctx.lvl   = priv;
        in_ctx.virt  = virt_on;
        in_ctx.has_s = has_smode;
        in_ctx.tw    = trap_wait;
        in_ctx.vtw   = vtrap_wait;
        in_ctx.tvm   = trap_vm;
        in_ctx.vtvm  = vtrap_vm;
        in_ctx.hu    = hyp_user;
        in_ctx.spvp  = spvp;
        in_ctx.gsum  = guest_sum;
        in_ctx.ro    = seed_ro;
    end

    plc_capture u_cap (
        .clk(clk), .rst(rst), .in_valid(op_valid), .in_ctx(in_ctx),
        .held_valid(held_valid), .held_ctx(held_ctx)
    );

    plc_rules u_rules (.ctx(held_ctx), .dec(dec));

    plc_emit #(.CAUSE_W(CAUSE_W), .ILL_CODE(ILL_CODE), .VIRT_CODE(VIRT_CODE)) u_emit (
        .valid(held_valid), .dec(dec),
        .out_valid(res_valid), .out_verdict(verdict), .out_cause(cause),
        .out_halt(halt_req), .out_flush(flush_req),
        .out_hls(hls_valid), .out_mode(hls_mode)
    );
endmodule

// File: rtl/plc_checker.sv
module plc_checker #(
    parameter int CAUSE_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               op_valid,
    input logic [2:0]         op_kind,
    input logic [1:0]         priv,
    input logic               virt_on,
    input logic               seed_ro,
    input logic               res_valid,
    input logic [1:0]         verdict,
    input logic [CAUSE_W-1:0] cause,
    input logic               halt_req,
    input logic               flush_req,
    input logic               hls_valid,
    input logic [2:0]         hls_mode
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) op_valid |=> res_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !op_valid |=> !res_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (verdict == 2'd0 && cause == '0 && !halt_req && !flush_req && !hls_valid)); // R1
    AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ((verdict == 2'd1) == (cause == CAUSE_W'(2)))); // R2
    AST_STROBE_PROCEED: assert property (@(posedge clk) disable iff (rst)
        (halt_req || flush_req || hls_valid) |-> (verdict == 2'd0)); // R2
    AST_GVIRT_VIRT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd3 && virt_on) |=> (verdict == 2'd2)); // R7
    AST_HLS_MACHINE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd5 && priv == 2'd3) |=> (verdict == 2'd0 && hls_valid)); // R9
    AST_TWO_STAGE: assert property (@(posedge clk) disable iff (rst) hls_valid |-> hls_mode[2]); // R10
    AST_SEED_RO: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_kind == 3'd7 && seed_ro) |=> (verdict == 2'd1)); // R11
endmodule

bind plc_top plc_checker #(.CAUSE_W(CAUSE_W)) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .priv(priv),
    .virt_on(virt_on), .seed_ro(seed_ro), .res_valid(res_valid), .verdict(verdict),
    .cause(cause), .halt_req(halt_req), .flush_req(flush_req),
    .hls_valid(hls_valid), .hls_mode(hls_mode)
);

// File: tb/plc_top_test.sv
module plc_top_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [2:0] op_kind = '0;
    logic [1:0] priv = '0;
    logic virt_on = 0, has_smode = 0, trap_wait = 0, vtrap_wait = 0;
    logic trap_vm = 0, vtrap_vm = 0, hyp_user = 0, spvp = 0, guest_sum = 0, seed_ro = 0;
    logic res_valid, halt_req, flush_req, hls_valid;
    logic [1:0] verdict;
    logic [4:0] cause;
    logic [2:0] hls_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    plc_top uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .priv(priv),
        .virt_on(virt_on), .has_smode(has_smode), .trap_wait(trap_wait),
        .vtrap_wait(vtrap_wait), .trap_vm(trap_vm), .vtrap_vm(vtrap_vm),
        .hyp_user(hyp_user), .spvp(spvp), .guest_sum(guest_sum), .seed_ro(seed_ro),
        .res_valid(res_valid), .verdict(verdict), .cause(cause), .halt_req(halt_req),
        .flush_req(flush_req), .hls_valid(hls_valid), .hls_mode(hls_mode)
    );

    // Packs {verdict, cause, halt, flush, hls, mode} into one word for comparison.
    function automatic logic [13:0] pack(input logic [1:0] v, input logic [4:0] c,
                                         input logic h, input logic f, input logic l,
                                         input logic [2:0] m);
        return {1'b0, v, c, h, f, l, m};
    endfunction

    // Expected result written from the requirement text.
    function automatic logic [13:0] expect_for(input int k, input int p, input logic [9:0] b);
        logic vi, sm, tw, vtw, tvm, vtvm, hu, sp, gs, ro;
        int v;   // 0 proceed, 1 illegal, 2 virt
        logic h, f, l;
        logic [2:0] m;
        {vi, sm, tw, vtw, tvm, vtvm, hu, sp, gs, ro} = b;
        v = 0; h = 0; f = 0; l = 0; m = 0;
        case (k)
            0: begin // R3 R4
                if ((p == 1 && tw) || (p == 0 && !sm && tw) || (p == 0 && sm && !vi)) v = 1;
                else if (vi && (p == 0 || (p == 1 && vtw))) v = 2;
                else h = 1;
            end
            1: begin // R5
                if (vi && p != 3 && vtw && !tw) v = 2;
                else if (p != 3 && tw) v = 1;
            end
            2: begin // R6
                if (!vi && (p == 0 || (p == 1 && tvm))) v = 1;
                else if (vi && (p == 0 || vtvm)) v = 2;
                else f = 1;
            end
            3, 4: begin // R7 R8
                if (k == 4 && p == 1 && !vi && tvm) v = 1;
                else if (vi) v = 2;
                else if (p != 0) f = 1;
                else v = 1;
            end
            5, 6: begin // R9 R10
                if (p == 3) l = 1;
                else if (vi) v = 2;
                else if (p == 0 && !hu) v = 1;
                else l = 1;
                if (l) m = {1'b1, (k == 5) & sp & gs, sp};
            end
            default: if (ro) v = 1; // R11
        endcase
        return pack(2'(v), (v == 1) ? 5'd2 : (v == 2) ? 5'd22 : 5'd0, h, f, l, m);
    endfunction

    task automatic check(input bit ok, input string req, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_check(input string req);
        logic [13:0] act;
        act = pack(verdict, cause, halt_req, flush_req, hls_valid, hls_mode);
        check(res_valid == 1'b0 && act == '0, req, {res_valid, act[12:0]}, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_check("R12 during reset");
        rst = 1'b0;
        @(negedge clk);
        idle_check("R12 after release");
        for (int k = 0; k < 8; k++) begin
            for (int pi = 0; pi < 3; pi++) begin
                for (int bits = 0; bits < 1024; bits++) begin
                    int p;
                    logic [13:0] exp, act;
                    string tag;
                    p = (pi == 2) ? 3 : pi;
                    op_kind = 3'(k);
                    priv = 2'(p);
                    {virt_on, has_smode, trap_wait, vtrap_wait, trap_vm, vtrap_vm,
                     hyp_user, spvp, guest_sum, seed_ro} = 10'(bits);
                    op_valid = 1'b1;
                    @(negedge clk);
                    op_valid = 1'b0;
                    exp = expect_for(k, p, 10'(bits));
                    act = pack(verdict, cause, halt_req, flush_req, hls_valid, hls_mode);
                    case (k)
                        0: tag = "R3/R4 wfi R2";
                        1: tag = "R5 wrs R2";
                        2: tag = "R6 sfence R2";
                        3: tag = "R7 gvirt fence";
                        4: tag = "R8 gphys fence";
                        5, 6: tag = "R9/R10 hls";
                        default: tag = "R11 seed";
                    endcase
                    check(res_valid === 1'b1 && act === exp, tag, act, exp);
                    if (bits == 1023) begin
                        @(negedge clk);
                        idle_check("R1 idle after result");
                    end
                end
            end
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule